// File: doc/BRIEF.md
# Serial Code Entry Comparator with Multiplexed Display

The block takes a short binary code that an operator keys in one bit at a time. A level input carries the bit value. A trigger input marks the moment it is taken. When the last bit of an entry arrives, the block compares the collected word with a fixed reference code that is set by a parameter. For a reference built from decimal digits, an odd digit maps to 1 and an even digit maps to 0, so the default is 11001.

The result appears on a bank of seven-segment digits that share one set of segment lines. Only one digit is driven at a time, so the bank is scanned one digit per slot. Each entered bit is shown on its own digit, and the next digit shows a verdict letter. The result stays lit for a fixed number of clock cycles. The bank then goes dark and the block accepts a new entry. A reset clears everything at any time.

Top module: `scode_display`

## Requirements
- R1: When the entered word equals `REF_CODE`, digit d6 (anode index `NUM_BITS`) shows 'E' as segment pattern 7'b1001111. Otherwise d6 shows 'n' as 7'b0010101. The pattern bit order is seg[6]=a down to seg[0]=g, and a 1 lights a segment.
- R2: Each rising edge of `trig` captures exactly one bit from `bit_in`. A trigger held high for many cycles still captures only one bit.
- R3: After `NUM_BITS` captures, digit k (anode index k, for k from 0 to `NUM_BITS`-1) shows the k-th captured bit. The first captured bit goes on d1 and is compared with the MSB of `REF_CODE`. A '0' is 7'b1111110 and a '1' is 7'b0110000.
- R4: While an entry is incomplete, including with no bits entered, every digit's segments are 0.
- R5: The result stays displayed for `HOLD_CYCLES` clock cycles. The bank then blanks and the block accepts a fresh entry.
- R6: Trigger edges that occur while a result is displayed are ignored. They are not counted toward the next entry.
- R7: A synchronous active-high `rst` blanks all digits from the next clock edge and discards any partial entry or displayed result.
- R8: Exactly one anode is high at any time. The active anode advances from index i to i+1, wrapping from `NUM_DIGITS`-1 to 0, once every `SCAN_DIV` clocks. Digit d7 (the last index) is always blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock, about 1 kHz in use |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Level carrying the bit value to capture |
| trig | input | 1 | Capture request; its rising edge takes one bit |
| anode | output | NUM_DIGITS | One-hot digit enable, index 0 is d1 |
| seg | output | 7 | Shared active-high segments, seg[6]=a to seg[0]=g |

## Verification
The bench sets `HOLD_CYCLES` to 40 instead of 5000, so the whole hold, the blanking afterwards and the re-arm all fit within a few scan rounds. Because of that, several full entries can run back to back, and presses can be aimed into the middle of a hold. `SCAN_DIV` is 1, so every clock moves the scan to a new digit. One full scan of seven samples is then enough to read back the whole shown result, and the measured lit window can be compared with the hold length to within one slot.

// File: rtl/scode_pkg.sv
package scode_pkg;

    localparam int SEG_W = 7;
    typedef logic [SEG_W-1:0] seg_t;

    // active-high segments, bit 6 = a ... bit 0 = g
    localparam seg_t SEG_BLANK = 7'b0000000;
    localparam seg_t SEG_ZERO  = 7'b1111110;
    localparam seg_t SEG_ONE   = 7'b0110000;
    localparam seg_t SEG_EQ    = 7'b1001111;
    localparam seg_t SEG_NE    = 7'b0010101;

    typedef enum logic {
        ST_ARM,
        ST_SHOW
    } scode_state_e;

    typedef struct packed {
        logic show;
        logic match;
    } scode_status_t;

    function automatic seg_t glyph_bit(input logic b);
        return b ? SEG_ONE : SEG_ZERO;
    endfunction

    function automatic seg_t glyph_verdict(input logic m);
        return m ? SEG_EQ : SEG_NE;
    endfunction

endpackage

// File: rtl/scode_trig_sync.sv
module scode_trig_sync (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic bit_in,
    output logic cap,
    output logic cap_bit
);
    logic [1:0] trig_s;
    logic [1:0] bit_s;
    logic       trig_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_s    <= '0;
            bit_s     <= '0;
            trig_prev <= 1'b0;
        end else begin
            trig_s    <= {trig_s[0], trig};
            bit_s     <= {bit_s[0], bit_in};
            trig_prev <= trig_s[1];
        end
    end

    always_comb begin
        cap     = trig_s[1] & ~trig_prev;
        cap_bit = bit_s[1];
    end

    // R2: one press yields a single-cycle capture strobe
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cap |=> !cap);

endmodule

// File: rtl/scode_entry.sv
module scode_entry
    import scode_pkg::*;
#(
    parameter int              NUM_BITS    = 5,
    parameter logic [NUM_BITS-1:0] REF_CODE = 5'b11001,
    parameter int              HOLD_CYCLES = 5000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap,
    input  logic                cap_bit,
    output logic [NUM_BITS-1:0] word,
    output scode_status_t       status
);
    localparam int CW = (NUM_BITS > 2) ? $clog2(NUM_BITS) : 1;
    localparam int TW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST  = CW'(NUM_BITS - 1);
    localparam logic [TW-1:0] TIME_LAST = TW'(HOLD_CYCLES - 1);

    scode_state_e        st_q;
    logic [CW-1:0]       cnt_q;
    logic [NUM_BITS-1:0] shift_q;
    logic [NUM_BITS-1:0] word_q;
    logic                match_q;
    logic [TW-1:0]       timer_q;
    logic [NUM_BITS-1:0] shift_n;

    always_comb shift_n = {shift_q[NUM_BITS-2:0], cap_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_ARM;
            cnt_q   <= '0;
            shift_q <= '0;
            word_q  <= '0;
            match_q <= 1'b0;
            timer_q <= '0;
        end else begin
            case (st_q)
                ST_ARM: begin
                    if (cap) begin
                        shift_q <= shift_n;
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            word_q  <= shift_n;
                            match_q <= (shift_n == REF_CODE);
                            timer_q <= '0;
                            st_q    <= ST_SHOW;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_SHOW: begin
                    if (timer_q == TIME_LAST) begin
                        timer_q <= '0;
                        st_q    <= ST_ARM;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: st_q <= ST_ARM;
            endcase
        end
    end

    always_comb begin
        word         = word_q;
        status.show  = (st_q == ST_SHOW);
        status.match = match_q;
    end

    // R5: the hold timer never runs past its window
    a_r5_timer_bound: assert property (@(posedge clk) disable iff (rst)
        timer_q <= TIME_LAST);

    // R6: a shown result is frozen until the block re-arms
    a_r6_word_frozen: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHOW) |=> (st_q == ST_ARM) || $stable(word_q));

    // R6: presses during a hold do not count toward the next entry
    a_r6_no_count_in_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHOW) |-> (cnt_q == '0));

    // R3: the bit counter stays within one entry
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);

endmodule

// File: rtl/scode_scan.sv
module scode_scan
    import scode_pkg::*;
#(
    parameter int NUM_BITS   = 5,
    parameter int NUM_DIGITS = 7,
    parameter int SCAN_DIV   = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_BITS-1:0]   word,
    input  scode_status_t         status,
    output logic [NUM_DIGITS-1:0] anode,
    output seg_t                  seg
);
    localparam int SW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam logic [SW-1:0] SLOT_LAST = SW'(NUM_DIGITS - 1);

    logic          tick;
    logic [SW-1:0] slot_q;

    generate
        if (SCAN_DIV > 1) begin : g_div
            localparam int DW = $clog2(SCAN_DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) div_q <= '0;
                else if (div_q == DW'(SCAN_DIV - 1)) div_q <= '0;
                else div_q <= div_q + 1'b1;
            end
            always_comb tick = (div_q == DW'(SCAN_DIV - 1));
        end else begin : g_nodiv
            always_comb tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else if (tick) slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end

    always_comb begin
        anode = '0;
        for (int d = 0; d < NUM_DIGITS; d++)
            if (slot_q == SW'(d)) anode[d] = 1'b1;
    end

    always_comb begin
        seg = SEG_BLANK;
        if (status.show) begin
            for (int k = 0; k < NUM_BITS; k++)
                if (slot_q == SW'(k)) seg = glyph_bit(word[NUM_BITS-1-k]);
            if (slot_q == SW'(NUM_BITS)) seg = glyph_verdict(status.match);
        end
    end

endmodule

// File: rtl/scode_display.sv
module scode_display
    import scode_pkg::*;
#(
    parameter int                  NUM_BITS    = 5,
    parameter logic [NUM_BITS-1:0] REF_CODE    = 5'b11001,
    parameter int                  HOLD_CYCLES = 5000,
    parameter int                  NUM_DIGITS  = 7,
    parameter int                  SCAN_DIV    = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_in,
    input  logic                  trig,
    output logic [NUM_DIGITS-1:0] anode,
    output logic [SEG_W-1:0]      seg
);
    logic                cap;
    logic                cap_bit;
    logic [NUM_BITS-1:0] word;
    scode_status_t       status;

    scode_trig_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .bit_in  (bit_in),
        .cap     (cap),
        .cap_bit (cap_bit)
    );

    scode_entry #(
        .NUM_BITS    (NUM_BITS),
        .REF_CODE    (REF_CODE),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_entry (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .cap_bit (cap_bit),
        .word    (word),
        .status  (status)
    );

    scode_scan #(
        .NUM_BITS   (NUM_BITS),
        .NUM_DIGITS (NUM_DIGITS),
        .SCAN_DIV   (SCAN_DIV)
    ) u_scan (
        .clk    (clk),
        .rst    (rst),
        .word   (word),
        .status (status),
        .anode  (anode),
        .seg    (seg)
    );

    // R8: exactly one digit enabled
    a_r8_one_anode: assert property (@(posedge clk) disable iff (rst)
        $countones(anode) == 1);

    // R8: the spare last digit never lights
    a_r8_last_blank: assert property (@(posedge clk) disable iff (rst)
        anode[NUM_DIGITS-1] |-> (seg == SEG_BLANK));

    // R4: nothing lit while an entry is still being collected
    a_r4_dark_when_arming: assert property (@(posedge clk) disable iff (rst)
        !status.show |-> (seg == SEG_BLANK));

    // R7: the cycle after reset the bank is dark
    a_r7_reset_blanks: assert property (@(posedge clk)
        rst |=> (seg == SEG_BLANK));

endmodule

// File: tb/scode_display_test.sv
module scode_display_test;
    localparam int NB = 5;
    localparam int ND = 7;
    localparam int H  = 40;
    localparam logic [NB-1:0] REFC = 5'b11001;

    localparam logic [6:0] P_ZERO = 7'b1111110;
    localparam logic [6:0] P_ONE  = 7'b0110000;
    localparam logic [6:0] P_EQ   = 7'b1001111;
    localparam logic [6:0] P_NE   = 7'b0010101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic trig = 1'b0;
    logic [ND-1:0] anode;
    logic [6:0] seg;

    always #5 clk = ~clk;

    scode_display #(
        .NUM_BITS(NB), .REF_CODE(REFC), .HOLD_CYCLES(H),
        .NUM_DIGITS(ND), .SCAN_DIV(1)
    ) uut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .trig(trig),
        .anode(anode), .seg(seg)
    );

    typedef struct packed {
        logic [NB-1:0] code;
        logic          hit;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic press(input logic b, input int len);
        @(negedge clk);
        bit_in = b;
        trig   = 1'b1;
        repeat (len) @(negedge clk);
        trig = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic enter(input logic [NB-1:0] code, input int len);
        exp_t e;
        e.code = code;
        e.hit  = (code == REFC);
        q.push_back(e);
        for (int i = NB - 1; i >= 0; i--) press(code[i], len);
    endtask

    task automatic expect_dark(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(seg == 7'd0, req, "segments dark", int'(seg), 0);
        end
    endtask

    // anode scan monitor (R8)
    initial begin
        logic [ND-1:0] prev;
        bit pv;
        pv = 0;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                pv = 0;
            end else begin
                check($countones(anode) == 1, "R8", "one anode", int'(anode), 1);
                if (pv)
                    check(anode == {prev[ND-2:0], prev[ND-1]}, "R8", "anode rotation",
                          int'(anode), int'({prev[ND-2:0], prev[ND-1]}));
                prev = anode;
                pv = 1;
            end
        end
    end

    // result scoreboard monitor (R1 R3 R5 R8)
    initial begin
        logic [6:0] got [ND];
        logic [6:0] want;
        exp_t e;
        int first, last, blanks;
        bit aborted;
        forever begin
            @(negedge clk);
            if (!rst && seg != 7'd0) begin
                first = cyc;
                for (int k = 0; k < ND; k++) got[k] = 7'h7f;
                for (int i = 0; i < ND; i++) begin
                    if (i > 0) @(negedge clk);
                    for (int k = 0; k < ND; k++) if (anode[k]) got[k] = seg;
                end
                if (q.size() == 0) begin
                    check(0, "R4", "unexpected lit display", int'(got[NB]), 0);
                end else begin
                    e = q.pop_front();
                    for (int k = 0; k < NB; k++) begin
                        want = e.code[NB-1-k] ? P_ONE : P_ZERO;
                        check(got[k] == want, "R3", $sformatf("bit digit %0d", k),
                              int'(got[k]), int'(want));
                    end
                    want = e.hit ? P_EQ : P_NE;
                    check(got[NB] == want, "R1", "verdict digit", int'(got[NB]), int'(want));
                    check(got[ND-1] == 7'd0, "R8", "last digit dark", int'(got[ND-1]), 0);
                end
                last = cyc;
                blanks = 0;
                aborted = 0;
                while (blanks < ND + 1) begin
                    @(negedge clk);
                    if (rst) begin
                        aborted = 1;
                        break;
                    end
                    if (seg != 7'd0) begin
                        last = cyc;
                        blanks = 0;
                    end else begin
                        blanks++;
                    end
                end
                if (!aborted)
                    check((last - first + 1 >= H - 2) && (last - first + 1 <= H), "R5",
                          "lit window length", last - first + 1, H);
            end
        end
    end

    // stimulus
    initial begin
        repeat (3) @(negedge clk);
        check(seg == 7'd0, "R7", "dark during reset", int'(seg), 0);
        rst = 1'b0;
        expect_dark(2 * ND, "R4");

        enter(5'b11001, 1);            // R1 match
        repeat (H + 2 * ND) @(negedge clk);
        enter(5'b00000, 1);            // R1 mismatch
        repeat (H + 2 * ND) @(negedge clk);
        enter(5'b11000, 1);            // R1 one-bit difference
        repeat (H + 2 * ND) @(negedge clk);

        enter(5'b11001, 12);           // R2 long presses capture once each
        press(1'b0, 1);                // R6 presses inside the hold
        press(1'b1, 1);
        press(1'b0, 1);
        repeat (H + 2 * ND) @(negedge clk);
        expect_dark(ND, "R5");         // R5 blank after hold, R6 nothing queued
        enter(5'b01010, 1);
        repeat (H + 2 * ND) @(negedge clk);

        press(1'b0, 1);                // R4 partial entry stays dark
        press(1'b0, 1);
        press(1'b0, 1);
        expect_dark(ND, "R4");
        @(negedge clk) rst = 1'b1;     // R7 partial entry discarded
        @(negedge clk);
        check(seg == 7'd0, "R7", "dark in reset", int'(seg), 0);
        rst = 1'b0;
        enter(5'b11001, 2);
        repeat (H + 2 * ND) @(negedge clk);

        enter(5'b11111, 1);            // R7 reset during a shown result
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(seg == 7'd0, "R7", "dark after reset", int'(seg), 0);
        rst = 1'b0;
        expect_dark(2 * ND, "R7");

        enter(5'b10101, 1);            // R5 re-arm back to back
        repeat (H + 2 * ND) @(negedge clk);
        enter(5'b01110, 1);
        repeat (H + 2 * ND) @(negedge clk);

        check(q.size() == 0, "R3", "all results shown", q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule